// File: doc/BRIEF.md
# Type 1 Configuration Forwarding Decoder

This block sits beside a bridge's address-phase logic and classifies each configuration cycle that carries a Type 1 address. It looks at the address/data bus, the command nibble and the side the cycle arrived on, and compares the addressed bus number against the bridge's primary, secondary and subordinate bus numbers. From these it picks one of four outcomes:
- pass the cycle on downstream unchanged,
- pass it on upstream unchanged,
- turn it into a special cycle on the far bus,
- or do nothing.

The outcome is registered on the first clock of a frame-start strobe and held until the next address phase. Two companion flags tell the queueing logic that the forwarded cycle must be handled as a delayed transaction and that it may move only one data word.

Top module: `cfg_type1_fwd_dec`

## Requirements
- R1: The decision code is 0 for no action, 1 for forward downstream, 2 for forward upstream and 3 for special cycle; any address whose bits [1:0] are not 01b gives code 0.
- R2: A cycle arriving on the primary side (`from_pri_i`=1) with command 1010b (read) or 1011b (write) gives code 1 when its bus number (address bits [23:16]) is greater than the secondary bus number and not greater than the subordinate bus number.
- R3: A cycle arriving on the secondary side gives code 2 only for command 1011b, device field [15:11] = 11111b, function field [10:8] = 111b, and a bus number below the secondary or above the subordinate number. A read with the same fields gives code 0.
- R4: A primary-side write with device 11111b and function 111b, addressed to the secondary bus number, gives code 3.
- R5: A secondary-side write with device 11111b and function 111b, addressed to the primary bus number, gives code 3. This takes precedence over code 2.
- R6: Every command other than 1010b and 1011b gives code 0, including the special-cycle command 0001b.
- R7: `dly_o` is 1 exactly when a write is forwarded (code 1 or 2). `one_beat_o` is 1 for a forwarded write or a special-cycle conversion, and 0 otherwise.
- R8: Outputs change only on the clock edge where `frame_i` is high after having been low. Holding `frame_i` high, or changing inputs while it is low, leaves them unchanged.
- R9: While `rst_n` is low the outputs are code 0 with both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_i | input | AD_W | Address/data bus during the address phase |
| cbe_i | input | 4 | Bus command nibble |
| frame_i | input | 1 | Frame-start strobe; a rising level marks the address phase |
| from_pri_i | input | 1 | 1 = cycle arrived on the primary side, 0 = secondary side |
| pri_bus_i | input | BUS_W | Primary bus number |
| sec_bus_i | input | BUS_W | Secondary bus number |
| sub_bus_i | input | BUS_W | Subordinate bus number |
| dec_o | output | 2 | Registered decision code |
| dly_o | output | 1 | Forwarded write needs delayed-transaction handling |
| one_beat_o | output | 1 | Transfer limited to a single data phase |

## Verification
The hardest case to reach is an upstream write that satisfies both the upstream-forward rule and the special-cycle rule. This happens when the addressed bus equals the primary bus number, which is always outside the secondary-to-subordinate window. The bench drives exactly that address, and also the neighbouring bus numbers, to confirm the priority.

The other awkward case is a strobe held high across two cycles with new address contents in the second cycle. The bench holds the strobe for an extra cycle while changing the bus, and checks that the outputs keep the first decision. A sweep over all bus numbers from 0 to 15, on both sides and with both commands, covers the boundaries of the exclusive and inclusive limits.

// File: rtl/cfgfwd_pkg.sv
package cfgfwd_pkg;

    typedef enum logic [1:0] {
        DEC_NONE    = 2'd0,
        DEC_DOWN    = 2'd1,
        DEC_UP      = 2'd2,
        DEC_SPECIAL = 2'd3
    } dec_e;

    localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
    localparam logic [3:0] CMD_SPC_CYC = 4'b0001;

    localparam logic [1:0] TYPE1_CODE  = 2'b01;
    localparam logic [4:0] DEV_ALL1    = 5'b11111;
    localparam logic [2:0] FN_ALL1     = 3'b111;

    typedef struct packed {
        dec_e dec;
        logic dly;
        logic one_beat;
    } verdict_t;

endpackage

// File: rtl/cfgfwd_addr_split.sv
module cfgfwd_addr_split #(
    parameter int AD_W  = 32,
    parameter int BUS_W = 8
) (
    input  logic [AD_W-1:0]  ad_i,
    output logic [BUS_W-1:0] bus_o,
    output logic [4:0]       dev_o,
    output logic [2:0]       fn_o,
    output logic [1:0]       kind_o
);
    localparam int BUS_LSB = 16;
    localparam int BUS_MSB = BUS_LSB + BUS_W - 1;

    always_comb begin
        bus_o  = ad_i[BUS_MSB:BUS_LSB];
        dev_o  = ad_i[15:11];
        fn_o   = ad_i[10:8];
        kind_o = ad_i[1:0];
    end
endmodule

// File: rtl/cfgfwd_range_chk.sv
module cfgfwd_range_chk #(
    parameter int BUS_W   = 8,
    parameter bit INCL_LO = 1'b1
) (
    input  logic [BUS_W-1:0] bus_i,
    input  logic [BUS_W-1:0] lo_i,
    input  logic [BUS_W-1:0] hi_i,
    output logic             inside_o
);
    logic lo_ok;

    generate
        if (INCL_LO) begin : g_incl
            always_comb lo_ok = (bus_i >= lo_i);
        end else begin : g_excl
            always_comb lo_ok = (bus_i > lo_i);
        end
    endgenerate

    always_comb inside_o = lo_ok && (bus_i <= hi_i);
endmodule

// File: rtl/cfgfwd_rules.sv
module cfgfwd_rules
    import cfgfwd_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0] bus_i,
    input  logic [4:0]       dev_i,
    input  logic [2:0]       fn_i,
    input  logic [1:0]       kind_i,
    input  logic [3:0]       cmd_i,
    input  logic             from_pri_i,
    input  logic [BUS_W-1:0] pri_bus_i,
    input  logic [BUS_W-1:0] sec_bus_i,
    input  logic             down_win_i,
    input  logic             bridge_win_i,
    output verdict_t         verdict_o
);
    logic is_rd, is_wr, is_cfg, is_t1, reserved_df;
    logic spc_down, spc_up, fwd_down, fwd_up;

    always_comb begin
        is_rd       = (cmd_i == CMD_CFG_RD);
        is_wr       = (cmd_i == CMD_CFG_WR);
        is_cfg      = is_rd || is_wr;
        is_t1       = (kind_i == TYPE1_CODE);
        reserved_df = (dev_i == DEV_ALL1) && (fn_i == FN_ALL1);

        spc_down = is_wr && reserved_df && (bus_i == sec_bus_i);
        spc_up   = is_wr && reserved_df && (bus_i == pri_bus_i);
        fwd_down = down_win_i;
        fwd_up   = is_wr && reserved_df && !bridge_win_i;

        verdict_o = '{dec: DEC_NONE, dly: 1'b0, one_beat: 1'b0};
        if (is_cfg && is_t1) begin
            if (from_pri_i) begin
                if (spc_down)      verdict_o.dec = DEC_SPECIAL;
                else if (fwd_down) verdict_o.dec = DEC_DOWN;
            end else begin
                if (spc_up)        verdict_o.dec = DEC_SPECIAL;
                else if (fwd_up)   verdict_o.dec = DEC_UP;
            end
        end
        verdict_o.dly = is_wr &&
            ((verdict_o.dec == DEC_DOWN) || (verdict_o.dec == DEC_UP));
        verdict_o.one_beat = verdict_o.dly || (verdict_o.dec == DEC_SPECIAL);
    end
endmodule

// File: rtl/cfg_type1_fwd_dec.sv
module cfg_type1_fwd_dec
    import cfgfwd_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [3:0]       cbe_i,
    input  logic             frame_i,
    input  logic             from_pri_i,
    input  logic [BUS_W-1:0] pri_bus_i,
    input  logic [BUS_W-1:0] sec_bus_i,
    input  logic [BUS_W-1:0] sub_bus_i,
    output logic [1:0]       dec_o,
    output logic             dly_o,
    output logic             one_beat_o
);
    typedef struct packed {
        logic     frame_seen;
        verdict_t v;
    } state_t;

    localparam state_t RESET_ST = '{frame_seen: 1'b0,
        v: '{dec: DEC_NONE, dly: 1'b0, one_beat: 1'b0}};

    logic [BUS_W-1:0] bus_w;
    logic [4:0]       dev_w;
    logic [2:0]       fn_w;
    logic [1:0]       kind_w;
    logic             down_win_w, bridge_win_w, capture_w;
    verdict_t         verdict_w;
    state_t           st_d, st_q;

    cfgfwd_addr_split #(.AD_W(AD_W), .BUS_W(BUS_W)) split_i (
        .ad_i(ad_i), .bus_o(bus_w), .dev_o(dev_w), .fn_o(fn_w), .kind_o(kind_w)
    );

    cfgfwd_range_chk #(.BUS_W(BUS_W), .INCL_LO(1'b0)) down_win_i (
        .bus_i(bus_w), .lo_i(sec_bus_i), .hi_i(sub_bus_i), .inside_o(down_win_w)
    );

    cfgfwd_range_chk #(.BUS_W(BUS_W), .INCL_LO(1'b1)) bridge_win_i (
        .bus_i(bus_w), .lo_i(sec_bus_i), .hi_i(sub_bus_i), .inside_o(bridge_win_w)
    );

    cfgfwd_rules #(.BUS_W(BUS_W)) rules_i (
        .bus_i(bus_w), .dev_i(dev_w), .fn_i(fn_w), .kind_i(kind_w),
        .cmd_i(cbe_i), .from_pri_i(from_pri_i),
        .pri_bus_i(pri_bus_i), .sec_bus_i(sec_bus_i),
        .down_win_i(down_win_w), .bridge_win_i(bridge_win_w),
        .verdict_o(verdict_w)
    );

    always_comb begin
        st_d            = st_q;
        capture_w       = frame_i && !st_q.frame_seen;
        st_d.frame_seen = frame_i;
        if (capture_w) st_d.v = verdict_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    always_comb begin
        dec_o      = st_q.v.dec;
        dly_o      = st_q.v.dly;
        one_beat_o = st_q.v.one_beat;
    end

    // R1: a non-Type-1 address never yields an action
    a_r1_not_type1: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_w && ad_i[1:0] != 2'b01) |=> (dec_o == 2'd0));

    // R3: an upstream read is never forwarded or converted
    a_r3_up_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_w && !from_pri_i && cbe_i == CMD_CFG_RD) |=> (dec_o == 2'd0));

    // R6: commands other than configuration read/write give no action
    a_r6_other_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_w && cbe_i != CMD_CFG_RD && cbe_i != CMD_CFG_WR) |=> (dec_o == 2'd0));

    // R7: the delayed flag only accompanies a forward with the single-beat flag
    a_r7_dly_implies_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        dly_o |-> (one_beat_o && (dec_o == 2'd1 || dec_o == 2'd2)));

    // R8: outputs hold outside the first strobe cycle
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_w |=> ($stable(dec_o) && $stable(dly_o) && $stable(one_beat_o)));

    // R2: a downstream forward lands inside the exclusive window
    a_r2_down_window: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_w && from_pri_i && !(bus_w > sec_bus_i && bus_w <= sub_bus_i)
         && !(bus_w == sec_bus_i)) |=> (dec_o == 2'd0));
endmodule

// File: tb/cfg_type1_fwd_dec_tb_top.sv
module cfg_type1_fwd_dec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic        frame = 1'b0;
    logic        from_pri = 1'b0;
    logic [7:0]  pri_bus = 8'd2;
    logic [7:0]  sec_bus = 8'd5;
    logic [7:0]  sub_bus = 8'd9;
    logic [1:0]  dec;
    logic        dly, one_beat;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];
    logic [3:0] last_exp = 4'b0000;

    always #2.5 clk = ~clk;

    cfg_type1_fwd_dec dut_i (
        .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_i(cbe), .frame_i(frame),
        .from_pri_i(from_pri), .pri_bus_i(pri_bus), .sec_bus_i(sec_bus),
        .sub_bus_i(sub_bus), .dec_o(dec), .dly_o(dly), .one_beat_o(one_beat)
    );

    function automatic logic [3:0] model(input logic side, input logic [31:0] a,
                                         input logic [3:0] c, input logic [7:0] p,
                                         input logic [7:0] s, input logic [7:0] u);
        logic [7:0] b = a[23:16];
        logic m = (a[15:11] == 5'h1f) && (a[10:8] == 3'h7);
        logic wr = (c == 4'hB);
        logic rd = (c == 4'hA);
        logic [1:0] d = 2'd0;
        logic dl, ob;
        if ((rd || wr) && a[1:0] == 2'b01) begin
            if (side) begin
                if (wr && m && b == s) d = 2'd3;
                else if (b > s && b <= u) d = 2'd1;
            end else begin
                if (wr && m && b == p) d = 2'd3;
                else if (wr && m && (b < s || b > u)) d = 2'd2;
            end
        end
        dl = wr && (d == 2'd1 || d == 2'd2);
        ob = dl || (d == 2'd3);
        return {d, dl, ob};
    endfunction

    function automatic logic [31:0] mk_ad(input logic [7:0] b, input logic [4:0] dv,
                                          input logic [2:0] f, input logic [1:0] k);
        return {8'h00, b, dv, f, 6'h00, k};
    endfunction

    task automatic issue(input logic side, input logic [31:0] a, input logic [3:0] c,
                         input string tag);
        item_t it;
        @(negedge clk);
        from_pri = side; ad = a; cbe = c; frame = 1'b1;
        last_exp = model(side, a, c, pri_bus, sec_bus, sub_bus);
        it.exp = last_exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        frame = 1'b0;
    endtask

    // strobe held for a second cycle with altered address, then low with new data
    task automatic issue_hold(input logic side, input logic [31:0] a, input logic [31:0] a2,
                              input logic [3:0] c);
        item_t it;
        @(negedge clk);
        from_pri = side; ad = a; cbe = c; frame = 1'b1;
        last_exp = model(side, a, c, pri_bus, sec_bus, sub_bus);
        it.exp = last_exp; it.tag = "R8 capture";
        sb_q.push_back(it);
        @(negedge clk);
        ad = a2;
        it.tag = "R8 held strobe";
        sb_q.push_back(it);
        @(negedge clk);
        frame = 1'b0; ad = a2 ^ 32'h00FF_0000; cbe = 4'h1;
        it.tag = "R8 strobe low";
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                total++;
                if ({dec, dly, one_beat} !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got dec=%0d dly=%0b one=%0b expected dec=%0d dly=%0b one=%0b",
                             it.tag, dec, dly, one_beat, it.exp[3:2], it.exp[1], it.exp[0]);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        // R9: reset state, with a strobe active during reset
        frame = 1'b1; ad = mk_ad(8'd6, 5'd0, 3'd0, 2'b01); cbe = 4'hA; from_pri = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        total++;
        if ({dec, dly, one_beat} !== 4'b0000) begin
            bad++;
            $display("FAIL R9: got %b expected 0000", {dec, dly, one_beat});
        end
        @(negedge clk); frame = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        issue(1, mk_ad(8'd6, 5'd3, 3'd1, 2'b01), 4'hA, "R2 down read inside");
        issue(1, mk_ad(8'd9, 5'd3, 3'd1, 2'b01), 4'hB, "R2 R7 down write at upper bound");
        issue(1, mk_ad(8'd5, 5'd3, 3'd1, 2'b01), 4'hA, "R2 bus equals secondary");
        issue(1, mk_ad(8'd10, 5'd3, 3'd1, 2'b01), 4'hB, "R2 above subordinate");
        issue(1, mk_ad(8'd5, 5'h1f, 3'd7, 2'b01), 4'hB, "R4 R7 down special");
        issue(1, mk_ad(8'd7, 5'd3, 3'd1, 2'b00), 4'hA, "R1 type0 bits");
        issue(1, mk_ad(8'd7, 5'd3, 3'd1, 2'b11), 4'hB, "R1 bits 11");
        issue(0, mk_ad(8'd20, 5'h1f, 3'd7, 2'b01), 4'hB, "R3 R7 up write outside");
        issue(0, mk_ad(8'd20, 5'h1f, 3'd7, 2'b01), 4'hA, "R3 up read blocked");
        issue(0, mk_ad(8'd5, 5'h1f, 3'd7, 2'b01), 4'hB, "R3 bus equals secondary inclusive");
        issue(0, mk_ad(8'd20, 5'h1e, 3'd7, 2'b01), 4'hB, "R3 device not all ones");
        issue(0, mk_ad(8'd20, 5'h1f, 3'd6, 2'b01), 4'hB, "R3 function not all ones");
        issue(0, mk_ad(8'd2, 5'h1f, 3'd7, 2'b01), 4'hB, "R5 up special priority");
        issue(0, mk_ad(8'd3, 5'h1f, 3'd7, 2'b01), 4'hB, "R5 neighbour of primary");
        issue(1, mk_ad(8'd6, 5'd3, 3'd1, 2'b01), 4'h1, "R6 special cycle command");
        issue(0, mk_ad(8'd2, 5'h1f, 3'd7, 2'b01), 4'h1, "R6 special cycle command up");
        issue(1, mk_ad(8'd6, 5'd3, 3'd1, 2'b01), 4'h6, "R6 memory read");
        issue(1, mk_ad(8'd6, 5'd3, 3'd1, 2'b01), 4'hB, "R8 setup");
        issue_hold(1, mk_ad(8'd7, 5'd0, 3'd0, 2'b01), mk_ad(8'd40, 5'd0, 3'd0, 2'b01), 4'hB);
        issue_hold(0, mk_ad(8'd30, 5'h1f, 3'd7, 2'b01), mk_ad(8'd2, 5'h1f, 3'd7, 2'b01), 4'hB);

        // sweep of bus numbers on both sides, both commands, reserved fields
        for (int b = 0; b < 16; b++) begin
            for (int sd = 0; sd < 2; sd++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    issue(sd[0], mk_ad(b[7:0], 5'h1f, 3'd7, 2'b01),
                          wr[0] ? 4'hB : 4'hA, "R2 R3 R4 R5 R7 sweep");
                end
            end
        end

        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule